// File: doc/BRIEF.md
# Queue Interrupt Source Selector

This block turns the per-queue status flags of a 64-queue engine into two interrupt lines, one for each half of the queues. Each queue in the lower half has a 3-bit selector. Its low two bits pick one of the four flags in that queue's status nibble, and its top bit inverts the picked flag. Each queue in the upper half always uses one fixed condition: the queue is not nearly empty.

The two halves are handled the same way. A queue latches a pending bit when its condition rises while the queue is enabled. Software clears pending bits by writing ones to them. Each interrupt line is active while any queue in its half is both pending and enabled. Software reaches the selectors, enables and pending bits through a word-addressed register port. Writes take effect at the clock edge, and reads are combinational.

Top module: `qirq_ctrl`

## Requirements
- R1: After reset, every register (word addresses 0 to 7) reads zero, and both interrupt lines are low.
- R2: Word addresses 0 to 3 hold the lower-half selectors, eight queues per word. Queue q uses bits 4*(q%8)+2 down to 4*(q%8) of word q/8. Bit 4*(q%8)+3 is reserved: writes to it are dropped and it reads zero. Writing one selector word leaves the other selector words unchanged.
- R3: For a lower queue, selector bits 1:0 pick a bit of that queue's status nibble `stat_lo_i[4q+3:4q]`, and selector bit 2 inverts the picked bit. Changes on the three status bits that are not picked never set the queue's pending bit.
- R4: Upper queue k uses the fixed condition `hi_near_empty_i[k] == 0`. Its interrupt goes to `irq_hi_o` and never to `irq_lo_o`.
- R5: A pending bit is set only on a 0-to-1 change of the queue's condition while the queue's enable bit is 1. A condition that is already true when the queue is enabled does not set it, and a falling condition does not set it.
- R6: Writing the pending register (address 6 for the lower half, 7 for the upper half) clears each bit written as 1 and leaves each bit written as 0 unchanged. Bit index is q mod 32.
- R7: When a set event and a write-1-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R8: Writing 0 to a queue's bit in the enable register (address 4 for the lower half, 5 for the upper half) also clears that queue's pending bit.
- R9: Each interrupt line is the OR, over its own half, of pending AND enable. The line is low whenever all enables of that half are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| stat_lo_i | input | 128 | Status nibble for each lower queue, queue q at bits 4q+3:4q |
| hi_near_empty_i | input | 32 | Nearly-empty flag for each upper queue |
| irq_lo_o | output | 1 | Interrupt line for the lower half |
| irq_hi_o | output | 1 | Interrupt line for the upper half |

## Verification
The bench steps one lower queue through all eight selector codes. For each code it first flips the three status bits that are not picked, which must leave the pending bit clear. It then flips the picked bit, which must set it. Together these separate a wrong index, a missing inversion and a stuck flag. On the upper half, the bench enables a queue whose condition is already true, and it also lets a condition fall. Both must leave the pending bit clear, which tells edge detection apart from level detection. It also lines up a rising condition with a clearing write in the same cycle, and it disables a queue that has a pending bit. These cases show whether set beats clear and whether disabling clears the pending bit.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
    localparam int unsigned SLOT_W  = 4;   // bits reserved per queue in a selector word
    localparam int unsigned SEL_W   = 3;   // used selector bits per queue
    localparam int unsigned INV_BIT = 2;   // selector bit that inverts the condition
    localparam int unsigned NIB_W   = 4;   // status flags per lower queue

    typedef enum logic [1:0] {
        FLAG_EMPTY       = 2'd0,
        FLAG_NEAR_EMPTY  = 2'd1,
        FLAG_NEAR_FULL   = 2'd2,
        FLAG_FULL        = 2'd3
    } flag_idx_e;
endpackage

// File: rtl/qirq_src_cfg.sv
module qirq_src_cfg
    import qirq_pkg::*;
#(
    parameter int unsigned HALF_Q = 32,
    parameter int unsigned DW     = 32,
    localparam int unsigned SPW    = DW / SLOT_W,
    localparam int unsigned NSW    = HALF_Q / SPW,
    localparam int unsigned WIDX_W = (NSW > 1) ? $clog2(NSW) : 1
)(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_en_i,
    input  logic [WIDX_W-1:0]       word_i,
    input  logic [DW-1:0]           wdata_i,
    output logic [HALF_Q*SEL_W-1:0] sel_o,
    output logic [DW-1:0]           rdata_o
);
    typedef struct packed {
        logic [HALF_Q-1:0][SEL_W-1:0] sel;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rdata_o = '0;
        for (int q = 0; q < HALF_Q; q++) begin
            if (wr_en_i && (word_i == WIDX_W'(q / SPW))) begin
                st_d.sel[q] = wdata_i[(q % SPW) * SLOT_W +: SEL_W];
            end
            if (word_i == WIDX_W'(q / SPW)) begin
                rdata_o[(q % SPW) * SLOT_W +: SEL_W] = st_q.sel[q];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sel_o = st_q.sel;
endmodule

// File: rtl/qirq_cond_sel.sv
module qirq_cond_sel
    import qirq_pkg::*;
#(
    parameter int unsigned HALF_Q = 32
)(
    input  logic [HALF_Q*NIB_W-1:0] stat_lo_i,
    input  logic [HALF_Q*SEL_W-1:0] sel_i,
    input  logic [HALF_Q-1:0]       hi_near_empty_i,
    output logic [HALF_Q-1:0]       cond_lo_o,
    output logic [HALF_Q-1:0]       cond_hi_o
);
    for (genvar q = 0; q < HALF_Q; q++) begin : g_lo
        logic [NIB_W-1:0] nib;
        logic [SEL_W-1:0] sel;
        flag_idx_e        idx;
        assign nib          = stat_lo_i[q*NIB_W +: NIB_W];
        assign sel          = sel_i[q*SEL_W +: SEL_W];
        assign idx          = flag_idx_e'(sel[1:0]);
        assign cond_lo_o[q] = nib[idx] ^ sel[INV_BIT];
    end

    // upper half: fixed source, queue holds more than its low mark
    assign cond_hi_o = ~hi_near_empty_i;
endmodule

// File: rtl/qirq_half.sv
module qirq_half #(
    parameter int unsigned N = 32
)(
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] cond_i,
    input  logic         en_wr_i,
    input  logic         pend_wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] en_o,
    output logic [N-1:0] pend_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] pend;
        logic [N-1:0] cond;
    } half_state_t;

    half_state_t  st_d, st_q;
    logic [N-1:0] rise, set, clr;

    always_comb begin
        rise      = cond_i & ~st_q.cond;
        set       = rise & st_q.en;
        clr       = pend_wr_i ? wdata_i : '0;
        st_d.cond = cond_i;
        st_d.en   = en_wr_i ? wdata_i : st_q.en;
        // set beats clear; a disabled queue drops its pending bit
        st_d.pend = ((st_q.pend & ~clr) | set) & st_d.en;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign irq_o  = |(st_q.pend & st_q.en);

    p_pend_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.pend & ~st_q.en) == '0));

    p_new_pend_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_q.pend & ~$past(st_q.pend) & ~$past(set)) == '0));

    p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_wr_i |=> ((st_q.pend & $past(clr & ~set)) == '0));

    p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(set) & st_q.en & ~st_q.pend) == '0));
endmodule

// File: rtl/qirq_ctrl.sv
module qirq_ctrl
    import qirq_pkg::*;
#(
    parameter int unsigned HALF_Q = 32,
    localparam int unsigned DW     = HALF_Q,
    localparam int unsigned SPW    = DW / SLOT_W,
    localparam int unsigned NSW    = HALF_Q / SPW,
    localparam int unsigned NREG   = NSW + 4,
    localparam int unsigned AW     = $clog2(NREG),
    localparam int unsigned WIDX_W = (NSW > 1) ? $clog2(NSW) : 1
)(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    reg_wr_i,
    input  logic [AW-1:0]           reg_addr_i,
    input  logic [DW-1:0]           reg_wdata_i,
    output logic [DW-1:0]           reg_rdata_o,
    input  logic [HALF_Q*NIB_W-1:0] stat_lo_i,
    input  logic [HALF_Q-1:0]       hi_near_empty_i,
    output logic                    irq_lo_o,
    output logic                    irq_hi_o
);
    localparam int unsigned A_EN_LO = NSW;
    localparam int unsigned A_EN_HI = NSW + 1;
    localparam int unsigned A_PD_LO = NSW + 2;
    localparam int unsigned A_PD_HI = NSW + 3;

    logic                    sel_hit;
    logic [DW-1:0]           sel_rdata;
    logic [HALF_Q*SEL_W-1:0] sel_flat;
    logic [HALF_Q-1:0]       cond_lo, cond_hi;
    logic [HALF_Q-1:0]       en_lo, en_hi, pend_lo, pend_hi;

    assign sel_hit = (reg_addr_i < AW'(NSW));

    qirq_src_cfg #(.HALF_Q(HALF_Q), .DW(DW)) u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (reg_wr_i && sel_hit),
        .word_i  (reg_addr_i[WIDX_W-1:0]),
        .wdata_i (reg_wdata_i),
        .sel_o   (sel_flat),
        .rdata_o (sel_rdata)
    );

    qirq_cond_sel #(.HALF_Q(HALF_Q)) u_cond (
        .stat_lo_i       (stat_lo_i),
        .sel_i           (sel_flat),
        .hi_near_empty_i (hi_near_empty_i),
        .cond_lo_o       (cond_lo),
        .cond_hi_o       (cond_hi)
    );

    qirq_half #(.N(HALF_Q)) u_lo (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cond_i    (cond_lo),
        .en_wr_i   (reg_wr_i && (reg_addr_i == AW'(A_EN_LO))),
        .pend_wr_i (reg_wr_i && (reg_addr_i == AW'(A_PD_LO))),
        .wdata_i   (reg_wdata_i),
        .en_o      (en_lo),
        .pend_o    (pend_lo),
        .irq_o     (irq_lo_o)
    );

    qirq_half #(.N(HALF_Q)) u_hi (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cond_i    (cond_hi),
        .en_wr_i   (reg_wr_i && (reg_addr_i == AW'(A_EN_HI))),
        .pend_wr_i (reg_wr_i && (reg_addr_i == AW'(A_PD_HI))),
        .wdata_i   (reg_wdata_i),
        .en_o      (en_hi),
        .pend_o    (pend_hi),
        .irq_o     (irq_hi_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (sel_hit) begin
            reg_rdata_o = sel_rdata;
        end else begin
            case (int'(reg_addr_i))
                A_EN_LO: reg_rdata_o = en_lo;
                A_EN_HI: reg_rdata_o = en_hi;
                A_PD_LO: reg_rdata_o = pend_lo;
                A_PD_HI: reg_rdata_o = pend_hi;
                default: reg_rdata_o = '0;
            endcase
        end
    end

    p_irq_lo_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_lo == '0) |-> !irq_lo_o);

    p_irq_hi_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_hi == '0) |-> !irq_hi_o);
endmodule

// File: tb/qirq_ctrl_tb.sv
module qirq_ctrl_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr = 1'b0;
    logic [2:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [127:0] stat_lo = '0;
    logic [31:0]  hi_ne = '1;
    logic         irq_lo, irq_hi;
    int           checks = 0;
    int           errors = 0;

    always #4 clk = ~clk;

    qirq_ctrl u_dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .reg_wr_i        (wr),
        .reg_addr_i      (addr),
        .reg_wdata_i     (wdata),
        .reg_rdata_o     (rdata),
        .stat_lo_i       (stat_lo),
        .hi_near_empty_i (hi_ne),
        .irq_lo_o        (irq_lo),
        .irq_hi_o        (irq_hi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            reg_rd(3'(a), v);
            chk($sformatf("R1 reset reg %0d", a), v, 32'h0);
        end
        chk("R1 reset irq_lo", {31'b0, irq_lo}, 32'h0);
        chk("R1 reset irq_hi", {31'b0, irq_hi}, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        reg_wr(3'd3, 32'hFFFF_FFFF);
        reg_rd(3'd3, v);
        chk("R2 reserved bits dropped", v, 32'h7777_7777);
        reg_wr(3'd0, 32'hA5A5_A5A5);
        reg_rd(3'd0, v);
        chk("R2 slot packing", v, 32'h2525_2525);
        reg_rd(3'd1, v);
        chk("R2 other word untouched", v, 32'h0);
        reg_wr(3'd3, 32'h0);
        reg_wr(3'd0, 32'h0);
    endtask

    // queue 9: word 1, slot 1 (bits 6:4)
    task automatic t_select();
        logic [31:0] v;
        logic [3:0]  nib;
        reg_wr(3'd4, 32'h0000_0200);
        for (int s = 0; s < 8; s++) begin
            reg_wr(3'd1, 32'(s) << 4);
            nib = s[2] ? 4'hF : 4'h0;
            @(negedge clk); stat_lo[39:36] = nib;
            settle();
            reg_wr(3'd6, 32'hFFFF_FFFF);
            nib = nib ^ (4'hF & ~(4'h1 << s[1:0]));
            @(negedge clk); stat_lo[39:36] = nib;
            settle();
            reg_rd(3'd6, v);
            chk($sformatf("R3 sel %0d unpicked flags ignored", s), v, 32'h0);
            nib = nib ^ (4'h1 << s[1:0]);
            @(negedge clk); stat_lo[39:36] = nib;
            settle();
            reg_rd(3'd6, v);
            chk($sformatf("R3 sel %0d picked flag sets", s), v, 32'h0000_0200);
            chk($sformatf("R9 sel %0d irq_lo", s), {31'b0, irq_lo}, 32'h1);
        end
        reg_wr(3'd4, 32'h0);
        reg_rd(3'd6, v);
        chk("R8 lower disable clears pending", v, 32'h0);
        chk("R9 irq_lo low when disabled", {31'b0, irq_lo}, 32'h0);
    endtask

    task automatic t_upper();
        logic [31:0] v;
        reg_wr(3'd5, 32'h0000_0020);
        reg_wr(3'd7, 32'hFFFF_FFFF);
        @(negedge clk); hi_ne[5] = 1'b0; hi_ne[6] = 1'b0;
        settle();
        reg_rd(3'd7, v);
        chk("R4 upper not-nearly-empty sets", v, 32'h0000_0020);
        chk("R4 irq_hi", {31'b0, irq_hi}, 32'h1);
        chk("R9 irq_lo unaffected", {31'b0, irq_lo}, 32'h0);
        // queue 38 already true when enabled
        reg_wr(3'd5, 32'h0000_0060);
        settle();
        reg_rd(3'd7, v);
        chk("R5 level at enable ignored", v, 32'h0000_0020);
        @(negedge clk); hi_ne[6] = 1'b1;
        settle();
        reg_rd(3'd7, v);
        chk("R5 falling ignored", v, 32'h0000_0020);
        @(negedge clk); hi_ne[6] = 1'b0;
        settle();
        reg_rd(3'd7, v);
        chk("R5 rising sets", v, 32'h0000_0060);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        reg_wr(3'd7, 32'h0);
        reg_rd(3'd7, v);
        chk("R6 zero write no effect", v, 32'h0000_0060);
        reg_wr(3'd7, 32'h0000_0020);
        reg_rd(3'd7, v);
        chk("R6 one clears only its bit", v, 32'h0000_0040);
        chk("R9 irq_hi still high", {31'b0, irq_hi}, 32'h1);
        reg_wr(3'd7, 32'h0000_0040);
        reg_rd(3'd7, v);
        chk("R6 all cleared", v, 32'h0);
        chk("R9 irq_hi low after clear", {31'b0, irq_hi}, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        @(negedge clk); hi_ne[6] = 1'b1;
        settle();
        @(negedge clk);
        hi_ne[6] = 1'b0;
        wr = 1'b1; addr = 3'd7; wdata = 32'h0000_0040;
        @(negedge clk);
        wr = 1'b0;
        reg_rd(3'd7, v);
        chk("R7 set beats clear", v, 32'h0000_0040);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        reg_wr(3'd5, 32'h0000_0020);
        reg_rd(3'd7, v);
        chk("R8 disable clears pending", v, 32'h0);
        reg_wr(3'd5, 32'h0000_0060);
        settle();
        reg_rd(3'd7, v);
        chk("R8 re-enable stays clear", v, 32'h0);
        chk("R8 irq_hi low", {31'b0, irq_hi}, 32'h0);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout();
        t_select();
        t_upper();
        t_w1c();
        t_collide();
        t_disable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule